// File: doc/BRIEF.md
# Serial NAND Bad-Block Scanner

After reset, this block walks every erase block of a serial NAND device in rising index order. It builds a bitmap of the blocks that are unusable, with one bit per block, and keeps a running count of the set bits. It contains its own SPI master. The master runs in mode 0: the clock idles low, MOSI changes on the falling edge, and MISO is sampled on the rising edge.

For each block the scanner sends three kinds of command:
- It moves the first page of the block into the device cache.
- It polls the device status until the device reports idle.
- It reads marker bytes from the spare area of that page.

A block is recorded as bad in either of two cases. The first is that its factory marker byte is anything other than 0xFF. The second is that a 32-bit user marker word in the spare area holds 0xDEADBEEF. If the device stays busy for too many polls, the scan stops and an error flag is raised.

Once the scan has finished, other logic can do two things. It can look up any block through a combinational query port. It can retire a further block with a one-cycle mark request.

Top module: `nand_badblk_scan`

## Requirements
- R1: The scan visits blocks 0 to NUM_BLOCKS-1 in ascending order. For each block it first sends a page load: byte 0x13, then a 24-bit row address equal to block << ROW_SHIFT, most significant byte first.
- R2: After each load, the scanner sends status polls. Each poll is byte 0x0F, then byte 0xC0, then one byte read back. Bit 0 of that byte set means busy. A busy reply causes another poll after at least POLL_GAP idle cycles. An idle reply moves on to the marker reads.
- R3: If POLL_MAX polls for one block all report busy, the scan aborts. scan_err goes high and stays high until reset, scan_done pulses, and no further command is issued.
- R4: The factory read is byte 0x03, a 16-bit column of 0x0800, one dummy byte, then one data byte. A value other than 0xFF marks the block bad, and no user-marker read is sent for that block.
- R5: The user read is byte 0x03, a 16-bit column of 0x0808, one dummy byte, then four data bytes assembled most significant byte first. A word equal to 0xDEADBEEF marks the block bad. Any other word, including the byte-reversed 0xEFBEADDE, leaves the block good.
- R6: bad_count is 0 after reset, never decreases, and always equals the number of set bits in the bitmap.
- R7: scan_done is high for exactly one cycle when the scan ends, and no command is issued after that.
- R8: query_bad shows the bitmap bit for query_idx in the same cycle, with no register in between. A value of 1 means bad.
- R9: A mark_req cycle sets the bit for mark_idx one cycle later. bad_count rises by one only if that bit was clear before.
- R10: spi_sclk is low whenever spi_cs_n is high, and spi_cs_n stays high for at least two SCLK periods (4*SCLK_DIV cycles) between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the scan starts when it is released |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| mark_req | input | 1 | Pulse that retires the block given on mark_idx |
| mark_idx | input | BLK_W | Index of the block to retire |
| query_idx | input | BLK_W | Index of the block to look up |
| query_bad | output | 1 | Bitmap bit for query_idx |
| bad_count | output | CNT_W | Number of bad blocks recorded |
| scan_done | output | 1 | One-cycle pulse when the scan ends |
| scan_err | output | 1 | Sticky flag: a block stayed busy through every poll |

## Verification
The bench sweeps an eight-block device in which each block carries a different marker pattern:
- a clean block;
- a zeroed or otherwise odd factory byte;
- the exact magic word;
- a magic word that differs in its last bit;
- the magic word stored byte-reversed;
- a bad factory byte combined with a valid magic word;
- a block that stays busy for several polls.

Between them, these patterns separate a marker check that compares correctly from one that is off by one bit, reads the word in the wrong byte order, or fails to skip the user read after a bad factory byte. A second scan holds one block busy past the poll limit. It shows whether the abort happens after exactly the limit and leaves the earlier results in place. Mark requests on good and on already-bad blocks show whether the count is bumped only for new bits.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;
    typedef enum logic [2:0] {ST_GAP, ST_BYTE, ST_WAIT, ST_EVAL, ST_PAUSE, ST_HALT} scan_st_e;
    typedef enum logic [1:0] {OP_LOAD, OP_POLL, OP_FACT, OP_USER} scan_op_e;

    localparam logic [7:0]  OPC_LOAD   = 8'h13;
    localparam logic [7:0]  OPC_GETF   = 8'h0F;
    localparam logic [7:0]  REG_STATUS = 8'hC0;
    localparam logic [7:0]  OPC_READ   = 8'h03;
    localparam logic [7:0]  FACT_GOOD  = 8'hFF;
    localparam logic [31:0] USER_MAGIC = 32'hDEADBEEF;
endpackage

// File: rtl/nbs_spi_byte.sv
`timescale 1ns/1ps
module nbs_spi_byte #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic             mosi;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sh   = tx;
                d.mosi = tx[7];
                d.bitn = 3'd0;
                d.cnt  = '0;
                d.sclk = 1'b0;
            end
        end else if (q.cnt == DIV_W'(DIV - 1)) begin
            d.cnt = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso};
            end else begin
                d.sclk = 1'b0;
                if (q.bitn == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bitn = q.bitn + 3'd1;
                    d.mosi = q.sh[6];
                    d.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk = q.sclk;
    assign mosi = q.mosi;
    assign rx   = q.rx;
    assign done = q.done;
endmodule

// File: rtl/nbs_bad_map.sv
`timescale 1ns/1ps
module nbs_bad_map #(
    parameter int N = 1024,
    localparam int IW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_set,
    input  logic [IW-1:0] scan_idx,
    input  logic          mark_req,
    input  logic [IW-1:0] mark_idx,
    input  logic [IW-1:0] query_idx,
    output logic          query_bad,
    output logic [CW-1:0] count,
    output logic [N-1:0]  map
);
    typedef struct packed {
        logic [N-1:0]  bits;
        logic [CW-1:0] cnt;
    } map_t;

    map_t q, d;
    logic scan_new, mark_new;

    always_comb begin
        d        = q;
        scan_new = scan_set && !q.bits[scan_idx];
        mark_new = mark_req && !q.bits[mark_idx] && !(scan_new && scan_idx == mark_idx);
        if (scan_set) d.bits[scan_idx] = 1'b1;
        if (mark_req) d.bits[mark_idx] = 1'b1;
        d.cnt = q.cnt + CW'(scan_new) + CW'(mark_new);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign query_bad = q.bits[query_idx];
    assign count     = q.cnt;
    assign map       = q.bits;
endmodule

// File: rtl/nand_badblk_scan.sv
`timescale 1ns/1ps
module nand_badblk_scan
    import nbs_pkg::*;
#(
    parameter int          NUM_BLOCKS = 1024,
    parameter int          ROW_SHIFT  = 6,
    parameter int          SCLK_DIV   = 2,
    parameter int          POLL_GAP   = 5000,
    parameter int          POLL_MAX   = 200,
    parameter logic [15:0] FACT_COL   = 16'h0800,
    parameter logic [15:0] USER_COL   = 16'h0808,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    input  logic             mark_req,
    input  logic [BLK_W-1:0] mark_idx,
    input  logic [BLK_W-1:0] query_idx,
    output logic             query_bad,
    output logic [CNT_W-1:0] bad_count,
    output logic             scan_done,
    output logic             scan_err
);
    localparam int CS_GAP  = 4 * SCLK_DIV;
    localparam int TMR_MAX = (POLL_GAP > CS_GAP) ? POLL_GAP : CS_GAP;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int TRY_W   = $clog2(POLL_MAX + 1);

    typedef struct packed {
        scan_st_e         st;
        scan_op_e         op;
        logic [BLK_W-1:0] blk;
        logic [2:0]       idx;
        logic [31:0]      rx;
        logic [TRY_W-1:0] tries;
        logic [TMR_W-1:0] tmr;
        logic             cs_n;
        logic             done;
        logic             err;
    } scan_t;

    scan_t       q, d;
    logic        x_start, x_done, scan_set, advance;
    logic [7:0]  x_tx, x_rx;
    logic [2:0]  last_idx;
    logic [23:0] row;
    logic [NUM_BLOCKS-1:0] bad_map;

    assign row = 24'(q.blk) << ROW_SHIFT;

    // byte to send and command length for the current command
    always_comb begin
        x_tx     = 8'h00;
        last_idx = 3'd0;
        unique case (q.op)
            OP_LOAD: begin
                last_idx = 3'd3;
                case (q.idx)
                    3'd0:    x_tx = OPC_LOAD;
                    3'd1:    x_tx = row[23:16];
                    3'd2:    x_tx = row[15:8];
                    default: x_tx = row[7:0];
                endcase
            end
            OP_POLL: begin
                last_idx = 3'd2;
                if (q.idx == 3'd0)      x_tx = OPC_GETF;
                else if (q.idx == 3'd1) x_tx = REG_STATUS;
            end
            OP_FACT, OP_USER: begin
                last_idx = (q.op == OP_FACT) ? 3'd4 : 3'd7;
                case (q.idx)
                    3'd0:    x_tx = OPC_READ;
                    3'd1:    x_tx = (q.op == OP_FACT) ? FACT_COL[15:8] : USER_COL[15:8];
                    3'd2:    x_tx = (q.op == OP_FACT) ? FACT_COL[7:0]  : USER_COL[7:0];
                    default: x_tx = 8'h00;
                endcase
            end
        endcase
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        x_start  = 1'b0;
        scan_set = 1'b0;
        advance  = 1'b0;
        unique case (q.st)
            ST_GAP: begin
                if (q.tmr == TMR_W'(CS_GAP - 1)) begin
                    d.tmr  = '0;
                    d.cs_n = 1'b0;
                    d.idx  = 3'd0;
                    d.st   = ST_BYTE;
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            ST_BYTE: begin
                x_start = 1'b1;
                d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (x_done) begin
                    d.rx = {q.rx[23:0], x_rx};
                    if (q.idx == last_idx) begin
                        d.cs_n = 1'b1;
                        d.st   = ST_EVAL;
                    end else begin
                        d.idx = q.idx + 3'd1;
                        d.st  = ST_BYTE;
                    end
                end
            end
            ST_EVAL: begin
                d.st = ST_GAP;
                unique case (q.op)
                    OP_LOAD: begin
                        d.op    = OP_POLL;
                        d.tries = '0;
                    end
                    OP_POLL: begin
                        if (!q.rx[0]) begin
                            d.op = OP_FACT;
                        end else if (q.tries == TRY_W'(POLL_MAX - 1)) begin
                            d.err  = 1'b1;
                            d.done = 1'b1;
                            d.st   = ST_HALT;
                        end else begin
                            d.tries = q.tries + TRY_W'(1);
                            d.st    = ST_PAUSE;
                        end
                    end
                    OP_FACT: begin
                        if (q.rx[7:0] != FACT_GOOD) begin
                            scan_set = 1'b1;
                            advance  = 1'b1;
                        end else begin
                            d.op = OP_USER;
                        end
                    end
                    OP_USER: begin
                        scan_set = (q.rx == USER_MAGIC);
                        advance  = 1'b1;
                    end
                endcase
                if (advance) begin
                    if (q.blk == BLK_W'(NUM_BLOCKS - 1)) begin
                        d.done = 1'b1;
                        d.st   = ST_HALT;
                    end else begin
                        d.blk = q.blk + BLK_W'(1);
                        d.op  = OP_LOAD;
                    end
                end
            end
            ST_PAUSE: begin
                if (q.tmr == TMR_W'(POLL_GAP - 1)) begin
                    d.tmr = '0;
                    d.st  = ST_GAP;
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            ST_HALT: d.st = ST_HALT;
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_GAP;
            q.op   <= OP_LOAD;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    nbs_spi_byte #(.DIV(SCLK_DIV)) eng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (x_start),
        .tx    (x_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .rx    (x_rx),
        .done  (x_done)
    );

    nbs_bad_map #(.N(NUM_BLOCKS)) map_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_set  (scan_set),
        .scan_idx  (q.blk),
        .mark_req  (mark_req),
        .mark_idx  (mark_idx),
        .query_idx (query_idx),
        .query_bad (query_bad),
        .count     (bad_count),
        .map       (bad_map)
    );

    assign spi_cs_n  = q.cs_n;
    assign scan_done = q.done;
    assign scan_err  = q.err;
endmodule

// File: rtl/nbs_checker.sv
`timescale 1ns/1ps
module nbs_checker #(
    parameter int N   = 1024,
    parameter int DIV = 2,
    localparam int IW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sclk,
    input logic          scan_done,
    input logic          scan_err,
    input logic [CW-1:0] bad_count,
    input logic          mark_req,
    input logic [IW-1:0] mark_idx,
    input logic [N-1:0]  bad_map
);
    logic [15:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                   gap_cnt <= '0;
        else if (!cs_n)               gap_cnt <= '0;
        else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
    end

    // R10: clock idles low while deselected
    p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
    // R10: minimum deselect time before every command
    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> gap_cnt >= 16'(4 * DIV));
    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) scan_done |=> !scan_done);
    // R3: error flag holds until reset
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n) scan_err |=> scan_err);
    // R6: count never goes down
    p_count_mono_r6: assert property (@(posedge clk) disable iff (!rst_n) bad_count >= $past(bad_count));
    // R6: count tracks the bitmap population
    p_count_pop_r6: assert property (@(posedge clk) disable iff (!rst_n) 32'(bad_count) == $countones(bad_map));
    // R9: a mark request sets its bit next cycle
    p_mark_sets_r9: assert property (@(posedge clk) disable iff (!rst_n) mark_req |=> bad_map[$past(mark_idx)]);
endmodule

bind nand_badblk_scan nbs_checker #(.N(NUM_BLOCKS), .DIV(SCLK_DIV)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .scan_done (scan_done),
    .scan_err  (scan_err),
    .bad_count (bad_count),
    .mark_req  (mark_req),
    .mark_idx  (mark_idx),
    .bad_map   (bad_map)
);

// File: tb/nand_badblk_scan_tb.sv
`timescale 1ns/1ps
module nand_badblk_scan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 8;
    localparam int DIV  = 2;
    localparam int PGAP = 6;
    localparam int PMAX = 4;

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, mosi, miso;
    logic mark_req, qbad, done, err;
    logic [2:0] mark_idx, query_idx;
    logic [3:0] cnt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_badblk_scan #(.NUM_BLOCKS(NB), .SCLK_DIV(DIV), .POLL_GAP(PGAP), .POLL_MAX(PMAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .mark_req(mark_req), .mark_idx(mark_idx), .query_idx(query_idx),
        .query_bad(qbad), .bad_count(cnt), .scan_done(done), .scan_err(err)
    );

    // ---------------- device model ----------------
    logic [7:0]  fac_v [NB];
    logic [31:0] usr_v [NB];
    int bsy [NB];
    int load_cnt [NB], load_row [NB], poll_cnt [NB], fac_rd [NB], usr_rd [NB];
    int bad_poll, total_cmds, cur_blk, busy_left, bitcnt;
    int sclk_viol, gap_viol, hi_run;
    bit seen_cmd;
    logic [7:0] rxb [16];
    logic [7:0] shreg;

    function automatic logic [7:0] spare_byte(int col);
        if (col == 'h800) return fac_v[cur_blk];
        if (col >= 'h808 && col <= 'h80B) return 8'(usr_v[cur_blk] >> (8 * (3 - (col - 'h808))));
        return 8'hFF;
    endfunction

    function automatic logic [7:0] resp(int k);
        if (rxb[0] == 8'h0F && k == 2) return {7'd0, busy_left > 0};
        if (rxb[0] == 8'h03 && k >= 4) return spare_byte(int'({rxb[1], rxb[2]}) + k - 4);
        return 8'h00;
    endfunction

    always @(negedge cs_n) begin
        bitcnt = 0;
        miso   = 1'b0;
    end

    always @(posedge sclk) if (cs_n === 1'b0) begin
        shreg  = {shreg[6:0], mosi};
        bitcnt = bitcnt + 1;
        if (bitcnt % 8 == 0 && bitcnt / 8 <= 16) rxb[bitcnt / 8 - 1] = shreg;
    end

    always @(negedge sclk) if (cs_n === 1'b0) begin
        logic [7:0] b;
        b    = resp(bitcnt / 8);
        miso = b[7 - bitcnt % 8];
    end

    always @(posedge cs_n) if (rst_n === 1'b1 && bitcnt >= 8) begin
        int n, row, col;
        n = bitcnt / 8;
        total_cmds = total_cmds + 1;
        if (rxb[0] == 8'h13 && n == 4) begin
            row = int'({rxb[1], rxb[2], rxb[3]});
            if ((row >> 6) < NB) begin
                cur_blk = row >> 6;
                load_cnt[cur_blk] = load_cnt[cur_blk] + 1;
                load_row[cur_blk] = row;
                busy_left = bsy[cur_blk];
            end
        end else if (rxb[0] == 8'h0F) begin
            if (rxb[1] != 8'hC0 || n != 3) bad_poll = bad_poll + 1;
            poll_cnt[cur_blk] = poll_cnt[cur_blk] + 1;
            if (busy_left > 0) busy_left = busy_left - 1;
        end else if (rxb[0] == 8'h03) begin
            col = int'({rxb[1], rxb[2]});
            if (col == 'h800 && n == 5) fac_rd[cur_blk] = fac_rd[cur_blk] + 1;
            if (col == 'h808 && n == 8) usr_rd[cur_blk] = usr_rd[cur_blk] + 1;
        end
        bitcnt = 0;
    end

    // R10 port-level monitor
    always @(negedge clk) if (rst_n === 1'b1) begin
        if (cs_n && sclk) sclk_viol = sclk_viol + 1;
        if (cs_n) hi_run = hi_run + 1;
        else begin
            if (seen_cmd && hi_run > 0 && hi_run < 4 * DIV) gap_viol = gap_viol + 1;
            if (hi_run > 0) seen_cmd = 1'b1;
            hi_run = 0;
        end
    end

    // ---------------- bench helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NB; i++) begin
            fac_v[i] = 8'hFF; usr_v[i] = 32'hFFFF_FFFF; bsy[i] = 0;
            load_cnt[i] = 0; load_row[i] = -1; poll_cnt[i] = 0; fac_rd[i] = 0; usr_rd[i] = 0;
        end
        bad_poll = 0; total_cmds = 0; cur_blk = 0; busy_left = 0; bitcnt = 0;
        sclk_viol = 0; gap_viol = 0; hi_run = 0; seen_cmd = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 60000; c++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        if (!ok) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R7 watchdog actual=0 expected=1");
        end
    endtask

    task automatic pulse_mark(input int idx);
        @(negedge clk);
        mark_req = 1'b1; mark_idx = 3'(idx);
        @(negedge clk);
        mark_req = 1'b0;
    endtask

    bit exp_bad [NB];

    initial begin
        bit ok;
        int snap;
        rst_n = 1'b0; mark_req = 1'b0; mark_idx = '0; query_idx = '0; miso = 1'b0;
        clear_model();
        // pattern sweep
        fac_v[1] = 8'h00;
        usr_v[2] = 32'hDEADBEEF;
        usr_v[3] = 32'hDEADBEEE;
        fac_v[4] = 8'hFE; usr_v[4] = 32'hDEADBEEF;
        usr_v[5] = 32'hEFBEADDE;
        bsy[6]   = 3;
        fac_v[7] = 8'h7F;
        for (int i = 0; i < NB; i++) exp_bad[i] = (fac_v[i] != 8'hFF) || (usr_v[i] == 32'hDEADBEEF);
        repeat (5) @(negedge clk);
        chk("R10 reset cs_n", int'(cs_n), 1);
        chk("R10 reset sclk", int'(sclk), 0);
        chk("R7 reset done", int'(done), 0);
        chk("R6 reset count", int'(cnt), 0);
        rst_n = 1'b1;
        wait_done(ok);
        if (ok) begin
            @(negedge clk);
            chk("R7 done width", int'(done), 0);
            chk("R3 no error", int'(err), 0);
            for (int b = 0; b < NB; b++) begin
                query_idx = 3'(b);
                #1;
                chk($sformatf("R8 query block %0d", b), int'(qbad), int'(exp_bad[b]));
                chk($sformatf("R1 row block %0d", b), load_row[b], b * 64);
                chk($sformatf("R1 loads block %0d", b), load_cnt[b], 1);
                chk($sformatf("R2 polls block %0d", b), poll_cnt[b], bsy[b] + 1);
                chk($sformatf("R4 factory reads block %0d", b), fac_rd[b], 1);
                chk($sformatf("R5 user reads block %0d", b), usr_rd[b], (fac_v[b] != 8'hFF) ? 0 : 1);
            end
            chk("R6 count after scan", int'(cnt), 4);
            chk("R2 poll format", bad_poll, 0);
            snap = total_cmds;
            repeat (200) @(negedge clk);
            chk("R7 silent after done", total_cmds, snap);
            // R9 marks
            pulse_mark(0);
            query_idx = 3'd0; #1;
            chk("R9 mark sets bit", int'(qbad), 1);
            chk("R9 count new mark", int'(cnt), 5);
            pulse_mark(1);
            chk("R9 count repeat mark", int'(cnt), 5);
            pulse_mark(3);
            query_idx = 3'd3; #1;
            chk("R9 mark block 3", int'(qbad), 1);
            chk("R9 count second new mark", int'(cnt), 6);
            chk("R10 sclk idle", sclk_viol, 0);
            chk("R10 cs gap", gap_viol, 0);
        end

        // timeout scan
        @(negedge clk);
        rst_n = 1'b0;
        clear_model();
        fac_v[1] = 8'h00;
        usr_v[2] = 32'hDEADBEEF;
        bsy[3]   = 10;
        repeat (3) @(negedge clk);
        chk("R6 count cleared", int'(cnt), 0);
        rst_n = 1'b1;
        wait_done(ok);
        if (ok) begin
            chk("R3 error raised", int'(err), 1);
            chk("R3 polls before abort", poll_cnt[3], PMAX);
            chk("R3 no read after abort", fac_rd[3], 0);
            chk("R3 next block untouched", load_cnt[4], 0);
            chk("R6 count at abort", int'(cnt), 2);
            snap = total_cmds;
            repeat (200) @(negedge clk);
            chk("R3 silent after abort", total_cmds, snap);
            chk("R3 error sticky", int'(err), 1);
            query_idx = 3'd2; #1;
            chk("R5 kept after abort", int'(qbad), 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule